// File: doc/BRIEF.md
# Vector condition-test bit packer

This block walks a run of 4-bit condition fields and reduces each one to a single bit. The reduce first compares each field bit against a pattern bit and keeps only the comparisons selected by a mask. It then takes the OR of those (any-match) or checks that every selected bit matched (all-match). The results are packed into 64-bit integer register images, and each image is emitted as a write request with a register index. Condition fields are read through a combinational select/value port, so the block holds no field storage.

After a one-cycle start strobe, the block takes a snapshot of its configuration. It then evaluates one element per cycle for VL elements, with VL from 1 to 64. A write is issued as soon as a register image is complete or the last element has been evaluated. A one-cycle done pulse follows the final write.

The source-side packing code, not any destination width, decides how many results share one destination register. A scalar destination collects every result bitwise in one register.

The controller has three states:

- `ST_IDLE` waits for `start`. The transition *launch* goes to `ST_RUN` and latches the configuration.
- `ST_RUN` evaluates one element per cycle. On the last element, the transition *finish* goes to `ST_DONE`.
- `ST_DONE` raises `done`. The transition *retire* goes back to `ST_IDLE`.

Top module: `cond_pack_seq`

## Requirements
- R1: The field selected for element i is `src_base + i` (modulo the number of fields, 16 by default) when `src_vec` is 1, and `src_base` for every element when `src_vec` is 0.
- R2: For field value v, bit j of the reduce term is `fmask[j] & (fpat[j] == v[j])`. With `any_mode` = 1 the result is the OR of the term bits. With `any_mode` = 0 the result is 1 exactly when the term equals `fmask`, so an all-zero mask gives 0 in any-match mode and 1 in all-match mode.
- R3: With `dst_vec` = 1, `pack_code` sets the results per register k: 0 gives 1, 1 gives 2, 2 gives 4, and 3 gives 8.
- R4: With `dst_vec` = 1, result i goes to register `(dst_base + i/k) mod 32`, at bit `i mod k` counted from the LSB.
- R5: Every bit of a written register image that holds no result of this run is zero.
- R6: With `dst_vec` = 0, result i goes to bit i of register `dst_base`, and exactly one write is issued, after the last element.
- R7: Element i is evaluated on the (i+1)-th rising edge after the edge that samples `start`. A write of a register that element i completes (or of the image when i is the last element) is visible for one cycle right after that edge.
- R8: After reset, `busy`, `wr_en` and `done` are 0. `busy` is 1 from the edge that samples `start` until `done` rises, and `done` is a single-cycle pulse in the cycle after the final write.
- R9: `start`, and any change on the configuration inputs, are ignored while `busy` is 1. The run in progress keeps the configuration sampled with its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, sampled while idle |
| vec_len | input | 7 | Element count VL, 1 to 64 |
| src_base | input | 4 | First condition field index |
| src_vec | input | 1 | 1: field index steps per element |
| fmask | input | 4 | Field bit select mask |
| fpat | input | 4 | Field bit match pattern |
| any_mode | input | 1 | 1: any-match, 0: all-match |
| pack_code | input | 2 | Results per destination register code |
| dst_base | input | 5 | First destination register index |
| dst_vec | input | 1 | 1: pack across registers, 0: single register |
| fld_sel | output | 4 | Condition field being read |
| fld_val | input | 4 | Contents of the selected field |
| busy | output | 1 | Run in progress |
| wr_en | output | 1 | Register write request valid |
| wr_idx | output | 5 | Register index of the write |
| wr_data | output | 64 | Assembled register image |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Counting from the rising edge that samples `start`, the write completed by element i is due just after edge i+1. The done pulse is due just after edge VL+1, and `busy` falls on that same edge. The bench computes, for every case, the cycle in which each write must appear. It then samples the outputs at each falling edge from cycle 1 to VL+1, so a write that is early, late, missing or extra is reported as a mismatch in that exact cycle. One extra falling edge after the pulse confirms that `done` has dropped.

// File: rtl/cpk_pkg.sv
package cpk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } cpk_state_e;

endpackage

// File: rtl/cpk_reduce.sv
module cpk_reduce #(
    parameter int FLD_W = 4
) (
    input  logic [FLD_W-1:0] field,
    input  logic [FLD_W-1:0] mask,
    input  logic [FLD_W-1:0] pat,
    input  logic             any_mode,
    output logic             hit
);
    logic [FLD_W-1:0] term;

    for (genvar b = 0; b < FLD_W; b++) begin : g_bit
        assign term[b] = mask[b] & (pat[b] == field[b]);
    end

    assign hit = any_mode ? (|term) : (term == mask);
endmodule

// File: rtl/cpk_slot.sv
module cpk_slot #(
    parameter int VL_W      = 7,
    parameter int POS_W     = 6,
    parameter int REG_IDX_W = 5
) (
    input  logic [VL_W-1:0]      elem,
    input  logic                 last,
    input  logic [1:0]           code,
    input  logic                 dvec,
    input  logic [REG_IDX_W-1:0] dbase,
    output logic [POS_W-1:0]     bit_pos,
    output logic [REG_IDX_W-1:0] reg_idx,
    output logic                 flush
);
    logic [POS_W-1:0] kmask;
    logic [POS_W-1:0] lane;
    logic [VL_W-1:0]  group;

    always_comb begin
        unique case (code)
            2'd0:    kmask = POS_W'(0);
            2'd1:    kmask = POS_W'(1);
            2'd2:    kmask = POS_W'(3);
            default: kmask = POS_W'(7);
        endcase
    end

    assign lane  = elem[POS_W-1:0] & kmask;
    assign group = elem >> code;

    always_comb begin
        if (dvec) begin
            bit_pos = lane;
            reg_idx = dbase + REG_IDX_W'(group);
            flush   = (lane == kmask) || last;
        end else begin
            bit_pos = elem[POS_W-1:0];
            reg_idx = dbase;
            flush   = last;
        end
    end
endmodule

// File: rtl/cond_pack_seq.sv
module cond_pack_seq
    import cpk_pkg::*;
#(
    parameter int FLD_W     = 4,
    parameter int FLD_IDX_W = 4,
    parameter int REG_W     = 64,
    parameter int REG_IDX_W = 5,
    parameter int VL_W      = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [VL_W-1:0]      vec_len,
    input  logic [FLD_IDX_W-1:0] src_base,
    input  logic                 src_vec,
    input  logic [FLD_W-1:0]     fmask,
    input  logic [FLD_W-1:0]     fpat,
    input  logic                 any_mode,
    input  logic [1:0]           pack_code,
    input  logic [REG_IDX_W-1:0] dst_base,
    input  logic                 dst_vec,
    output logic [FLD_IDX_W-1:0] fld_sel,
    input  logic [FLD_W-1:0]     fld_val,
    output logic                 busy,
    output logic                 wr_en,
    output logic [REG_IDX_W-1:0] wr_idx,
    output logic [REG_W-1:0]     wr_data,
    output logic                 done
);
    localparam int POS_W = $clog2(REG_W);

    cpk_state_e state_q, state_d;

    logic [VL_W-1:0]      vl_q, elem_q;
    logic [FLD_IDX_W-1:0] sbase_q;
    logic                 svec_q, any_q, dvec_q;
    logic [FLD_W-1:0]     mask_q, pat_q;
    logic [1:0]           code_q;
    logic [REG_IDX_W-1:0] dbase_q;
    logic [REG_W-1:0]     acc_q, acc_nx;

    logic                 last, hit, flush;
    logic [POS_W-1:0]     bit_pos;
    logic [REG_IDX_W-1:0] reg_idx;

    assign last    = (elem_q == vl_q - VL_W'(1));
    assign fld_sel = sbase_q + (svec_q ? elem_q[FLD_IDX_W-1:0] : '0);
    assign busy    = (state_q != ST_IDLE);
    assign acc_nx  = acc_q | (REG_W'(hit) << bit_pos);

    cpk_reduce #(.FLD_W(FLD_W)) reduce_i (
        .field    (fld_val),
        .mask     (mask_q),
        .pat      (pat_q),
        .any_mode (any_q),
        .hit      (hit)
    );

    cpk_slot #(.VL_W(VL_W), .POS_W(POS_W), .REG_IDX_W(REG_IDX_W)) slot_i (
        .elem    (elem_q),
        .last    (last),
        .code    (code_q),
        .dvec    (dvec_q),
        .dbase   (dbase_q),
        .bit_pos (bit_pos),
        .reg_idx (reg_idx),
        .flush   (flush)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: launch, finish, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (last)  state_d = ST_DONE;
            ST_DONE:            state_d = ST_IDLE;
            default:            state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q    <= '0;
            elem_q  <= '0;
            sbase_q <= '0;
            svec_q  <= 1'b0;
            any_q   <= 1'b0;
            dvec_q  <= 1'b0;
            mask_q  <= '0;
            pat_q   <= '0;
            code_q  <= '0;
            dbase_q <= '0;
            acc_q   <= '0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
            done    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            done  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        vl_q    <= vec_len;
                        sbase_q <= src_base;
                        svec_q  <= src_vec;
                        mask_q  <= fmask;
                        pat_q   <= fpat;
                        any_q   <= any_mode;
                        code_q  <= pack_code;
                        dbase_q <= dst_base;
                        dvec_q  <= dst_vec;
                        elem_q  <= '0;
                        acc_q   <= '0;
                    end
                end
                ST_RUN: begin
                    elem_q <= elem_q + VL_W'(1);
                    if (flush) begin
                        wr_en   <= 1'b1;
                        wr_idx  <= reg_idx;
                        wr_data <= acc_nx;
                        acc_q   <= '0;
                    end else begin
                        acc_q   <= acc_nx;
                    end
                end
                ST_DONE: done <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cpk_checker.sv
module cpk_checker #(
    parameter int REG_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic             done,
    input logic             dst_vec,
    input logic [1:0]       pack_code
);
    logic             cap_vec;
    logic [1:0]       cap_code;
    logic [REG_W-1:0] keep_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_vec  <= 1'b0;
            cap_code <= '0;
        end else if (start && !busy) begin
            cap_vec  <= dst_vec;
            cap_code <= pack_code;
        end
    end

    always_comb begin
        unique case (cap_code)
            2'd0:    keep_mask = REG_W'(8'h01);
            2'd1:    keep_mask = REG_W'(8'h03);
            2'd2:    keep_mask = REG_W'(8'h0F);
            default: keep_mask = REG_W'(8'hFF);
        endcase
    end

    AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cap_vec) |-> ((wr_data & ~keep_mask) == '0)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en)); // R8
    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_en); // R7
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R8
    AST_DONE_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
endmodule

bind cond_pack_seq cpk_checker #(.REG_W(REG_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .done      (done),
    .dst_vec   (dst_vec),
    .pack_code (pack_code)
);

// File: tb/cond_pack_seq_tb.sv
module cond_pack_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCASE = 8;

    // entry: vl[28:22] sbase[21:18] svec[17] mask[16:13] pat[12:9] any[8] code[7:6] dbase[5:1] dvec[0]
    localparam logic [28:0] TBL [NCASE] = '{
        {7'd1,  4'd0,  1'b1, 4'hF, 4'hF, 1'b1, 2'd0, 5'd3,  1'b1},
        {7'd10, 4'd2,  1'b1, 4'h5, 4'h4, 1'b0, 2'd1, 5'd0,  1'b1},
        {7'd13, 4'd5,  1'b1, 4'hF, 4'h0, 1'b1, 2'd2, 5'd30, 1'b1},
        {7'd17, 4'd1,  1'b1, 4'h3, 4'h3, 1'b0, 2'd3, 5'd7,  1'b1},
        {7'd64, 4'd0,  1'b1, 4'h8, 4'h8, 1'b1, 2'd3, 5'd2,  1'b0},
        {7'd5,  4'd9,  1'b0, 4'h6, 4'h2, 1'b0, 2'd2, 5'd4,  1'b1},
        {7'd20, 4'd15, 1'b1, 4'h0, 4'h0, 1'b0, 2'd0, 5'd10, 1'b0},
        {7'd8,  4'd3,  1'b1, 4'h0, 4'h0, 1'b1, 2'd2, 5'd1,  1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  vec_len = '0;
    logic [3:0]  src_base = '0;
    logic        src_vec = 1'b0;
    logic [3:0]  fmask = '0;
    logic [3:0]  fpat = '0;
    logic        any_mode = 1'b0;
    logic [1:0]  pack_code = '0;
    logic [4:0]  dst_base = '0;
    logic        dst_vec = 1'b0;
    logic [3:0]  fld_sel;
    logic [3:0]  fld_val;
    logic        busy, wr_en, done;
    logic [4:0]  wr_idx;
    logic [63:0] wr_data;

    logic [3:0]  fld_mem [16];
    int          tests = 0;
    int          fails = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign fld_val = fld_mem[fld_sel];

    cond_pack_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
        .src_base(src_base), .src_vec(src_vec), .fmask(fmask), .fpat(fpat),
        .any_mode(any_mode), .pack_code(pack_code), .dst_base(dst_base),
        .dst_vec(dst_vec), .fld_sel(fld_sel), .fld_val(fld_val), .busy(busy),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [28:0] e, input bit restrike);
        int          vl    = int'(e[28:22]);
        int          sb    = int'(e[21:18]);
        bit          sv    = e[17];
        logic [3:0]  m     = e[16:13];
        logic [3:0]  p     = e[12:9];
        bit          anym  = e[8];
        int          code  = int'(e[7:6]);
        int          db    = int'(e[5:1]);
        bit          dv    = e[0];
        int          k     = 1 << code;
        bit          ev [66];
        logic [4:0]  ei [66];
        logic [63:0] ed [66];
        logic [63:0] accum = '0;
        string       tag   = dv ? "R1 R2 R3 R4 R5 R7" : "R1 R2 R6 R7";
        for (int c = 0; c < 66; c++) begin
            ev[c] = 1'b0; ei[c] = '0; ed[c] = '0;
        end
        for (int i = 0; i < vl; i++) begin
            logic [3:0] v = fld_mem[sv ? (sb + i) % 16 : sb];
            logic [3:0] n = m & ~(p ^ v);
            bit r = anym ? (n != 0) : (n == m);
            int pos = dv ? i % k : i;
            accum[pos] = r;
            if ((dv && ((i % k) == k - 1)) || i == vl - 1) begin
                ev[i+1] = 1'b1;
                ei[i+1] = dv ? 5'((db + i / k) % 32) : 5'(db);
                ed[i+1] = accum;
                accum   = '0;
            end
        end
        @(negedge clk);
        vec_len = 7'(vl); src_base = 4'(sb); src_vec = sv; fmask = m; fpat = p;
        any_mode = anym; pack_code = 2'(code); dst_base = 5'(db); dst_vec = dv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: scramble configuration while running
        fmask = ~m; fpat = ~p; any_mode = ~anym; pack_code = ~pack_code;
        dst_base = dst_base + 5'd9; dst_vec = ~dv; src_vec = ~sv; vec_len = 7'd3;
        for (int c = 1; c <= vl + 1; c++) begin
            @(negedge clk);
            if (ev[c])
                chk(wr_en && wr_idx == ei[c] && wr_data == ed[c], tag,
                    {wr_en, 58'(wr_idx), 5'd0} ^ wr_data, ed[c]);
            else if (wr_en)
                chk(1'b0, "R7 unexpected write", wr_data, '0);
            if (c <= vl) begin
                if (done || !busy) chk(1'b0, "R8 busy/done during run", {busy, done}, 64'h2);
            end else begin
                chk(done && !busy, "R8 done pulse", {busy, done}, 64'h1);
            end
            if (restrike) start = (c == 2);
            if (restrike && c == 3) start = 1'b0;
        end
        start = 1'b0;
        @(negedge clk);
        chk(!done && !busy && !wr_en, "R8 done single cycle", {wr_en, busy, done}, '0);
        if (restrike) begin
            repeat (3) @(negedge clk);
            chk(!busy && !wr_en, "R9 restart ignored while busy", {wr_en, busy}, '0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < 16; j++) fld_mem[j] = 4'((j * 7 + 3) % 16);
        repeat (3) @(negedge clk);
        chk(!busy && !wr_en && !done, "R8 reset state", {busy, wr_en, done}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !wr_en && !done, "R8 idle after reset", {busy, wr_en, done}, '0);
        for (int t = 0; t < NCASE; t++) run_case(TBL[t], 1'b0);
        // R9: second start inside a run
        run_case({7'd6, 4'd4, 1'b1, 4'hA, 4'h2, 1'b1, 2'd1, 5'd12, 1'b1}, 1'b1);
        // R4: wraparound of destination index with two per register
        run_case({7'd9, 4'd14, 1'b1, 4'hC, 4'h4, 1'b0, 2'd1, 5'd31, 1'b1}, 1'b0);
        // R6: scalar destination with scalar source, any-match
        run_case({7'd33, 4'd6, 1'b0, 4'h9, 4'h1, 1'b1, 2'd0, 5'd20, 1'b0}, 1'b0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule